// File: doc/BRIEF.md
# Strap-configured memory row selector

This block picks one of eight memory rows on a RAM expansion card. The row number is three bits wide. The top bit either comes from one bank-address bit or is tied high. The CPU drives the bank address onto the data bus early in each cycle, and a one-bit register captures the chosen bit during that window. The two lower bits either follow the two row-select strobes from the host or are tied high. Five strap inputs set the row size and how many rows are fitted.

Tying row-number bits high on a card that is only partly populated makes the unused address combinations repeat the rows that are fitted. Every bank of the card space then lands on a real row, so there are no holes. For example, a single fitted row answers every bank as row 7, and two fitted rows alternate between rows 6 and 7.

A third strap drives a size line back to the host, high for small (256 KB) rows and low for large (1 MB) rows. The row outputs are one-hot and are live only while the card is selected. The asynchronous active-low reset is released through a short synchronizer.

Top module: `mem_row_selector`

## Requirements
- R1: While `card_sel_i` is low, `row_sel_o` is all zeros.
- R2: While `card_sel_i` is high, exactly one bit of `row_sel_o` is set, namely bit number {top, mid, low} (top is the most significant bit).
- R3: With `strap_top_bus_i` = 0, the top bit is 1, so one of rows 4 to 7 is selected.
- R4: With `strap_top_bus_i` = 1, the top bit is the value of the data-bus bit captured at the last rising clock edge that saw `bank_win_i` high. That bit is data bit 4 when `strap_bit_hi_i` = 0 and data bit 6 when `strap_bit_hi_i` = 1.
- R5: At edges where `bank_win_i` is low, the captured bit keeps its value whatever the data bus does.
- R6: `mem_size_o` equals `strap_size_small_i`: 1 means 256 KB rows, 0 means 1 MB rows.
- R7: With `strap_low_strobe_i` = 0, the low row bit is 1 (an odd row). With `strap_low_strobe_i` = 1, the low row bit follows `row_strobe_i[0]`.
- R8: With `strap_mid_strobe_i` = 0, the middle row bit is 1. With `strap_mid_strobe_i` = 1, the middle row bit follows `row_strobe_i[1]`.
- R9: With all three row-bit straps set to force (`strap_top_bus_i`, `strap_mid_strobe_i` and `strap_low_strobe_i` all 0), a selected card always drives row 7.
- R10: After reset, the captured bit is 0 until the first capture window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bank_win_i | input | 1 | High while the bank address is on the data bus |
| data_i | input | 8 | Data bus |
| row_strobe_i | input | 2 | Row-select strobes from the host |
| card_sel_i | input | 1 | Card space addressed |
| strap_top_bus_i | input | 1 | 1: top bit taken from the captured bus bit; 0: top bit forced high |
| strap_bit_hi_i | input | 1 | 0: capture data bit 4; 1: capture data bit 6 |
| strap_size_small_i | input | 1 | Row-size strap driving the size line |
| strap_mid_strobe_i | input | 1 | 1: middle bit from strobe 1; 0: forced high |
| strap_low_strobe_i | input | 1 | 1: low bit from strobe 0; 0: forced high |
| row_sel_o | output | 8 | One-hot row select |
| mem_size_o | output | 1 | Size line to the host |

## Verification
The bench sweeps every combination of the five straps, the four strobe patterns, the four values of data bits 4 and 6, and both levels of card select.

- Complementing the data bus after each capture window shows that the value held in the register is the one used, not the live bus.
- Because bits 4 and 6 are driven independently, picking the wrong bit gives a wrong row.
- The forced-strap cases show the aliasing onto row 7 and onto rows 6 and 7.
- The first check after reset shows the cleared capture register.

// File: rtl/mem_row_pkg.sv
package mem_row_pkg;
  localparam int unsigned ROW_BITS = 3;
  localparam int unsigned NUM_ROWS = 1 << ROW_BITS;

  typedef logic [ROW_BITS-1:0] row_num_t;
  typedef logic [NUM_ROWS-1:0] row_vec_t;

  typedef struct packed {
    logic top_from_bus;
    logic bit_hi;
    logic size_small;
    logic mid_from_strobe;
    logic low_from_strobe;
  } strap_t;
endpackage

// File: rtl/mrs_reset_sync.sv
module mrs_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/mrs_bank_latch.sv
module mrs_bank_latch #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LO_IDX = 4,
  parameter int unsigned HI_IDX = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic              pick_hi_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bit_q_o
);
  logic bit_q;
  logic bit_d;

  always_comb begin
    bit_d = pick_hi_i ? data_i[HI_IDX] : data_i[LO_IDX];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bit_q <= 1'b0;
    else if (cap_en_i) bit_q <= bit_d;
  end

  assign bit_q_o = bit_q;

  // R5
  hold_outside_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> $stable(bit_q_o));
endmodule

// File: rtl/mrs_row_builder.sv
module mrs_row_builder
  import mem_row_pkg::*;
(
  input  strap_t     straps_i,
  input  logic       bank_bit_i,
  input  logic [1:0] strobe_i,
  output row_num_t   row_num_o
);
  logic top_b, mid_b, low_b;

  always_comb begin
    top_b     = straps_i.top_from_bus    ? bank_bit_i  : 1'b1;
    mid_b     = straps_i.mid_from_strobe ? strobe_i[1] : 1'b1;
    low_b     = straps_i.low_from_strobe ? strobe_i[0] : 1'b1;
    row_num_o = {top_b, mid_b, low_b};
  end
endmodule

// File: rtl/mrs_row_decoder.sv
module mrs_row_decoder
  import mem_row_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  row_num_t num_i,
  output row_vec_t sel_o
);
  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    assign sel_o[i] = en_i && (num_i == row_num_t'(i));
  end

  // R2
  onehot_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> $countones(sel_o) == 1);
  // R1
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> sel_o == '0);
endmodule

// File: rtl/mem_row_selector.sv
module mem_row_selector
  import mem_row_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned LO_BIT_IDX  = 4,
  parameter int unsigned HI_BIT_IDX  = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bank_win_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        row_strobe_i,
  input  logic              card_sel_i,
  input  logic              strap_top_bus_i,
  input  logic              strap_bit_hi_i,
  input  logic              strap_size_small_i,
  input  logic              strap_mid_strobe_i,
  input  logic              strap_low_strobe_i,
  output logic [NUM_ROWS-1:0] row_sel_o,
  output logic              mem_size_o
);
  strap_t   straps;
  logic     rst_int_n;
  logic     bank_bit;
  row_num_t row_num;

  assign straps = '{top_from_bus:    strap_top_bus_i,
                    bit_hi:          strap_bit_hi_i,
                    size_small:      strap_size_small_i,
                    mid_from_strobe: strap_mid_strobe_i,
                    low_from_strobe: strap_low_strobe_i};

  mrs_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_int_n));

  mrs_bank_latch #(.DATA_W(DATA_W), .LO_IDX(LO_BIT_IDX), .HI_IDX(HI_BIT_IDX)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_int_n), .cap_en_i(bank_win_i),
    .pick_hi_i(straps.bit_hi), .data_i(data_i), .bit_q_o(bank_bit));

  mrs_row_builder u_build (
    .straps_i(straps), .bank_bit_i(bank_bit), .strobe_i(row_strobe_i),
    .row_num_o(row_num));

  mrs_row_decoder u_dec (
    .clk_i(clk_i), .rst_ni(rst_int_n), .en_i(card_sel_i),
    .num_i(row_num), .sel_o(row_sel_o));

  assign mem_size_o = straps.size_small;

  // R3
  top_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (card_sel_i && !strap_top_bus_i) |-> row_sel_o[NUM_ROWS-1:NUM_ROWS/2] != '0);
  // R7
  odd_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (card_sel_i && !strap_low_strobe_i) |-> (row_sel_o & 8'h55) == '0);
  // R9
  single_row_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (card_sel_i && !strap_top_bus_i && !strap_mid_strobe_i && !strap_low_strobe_i)
      |-> row_sel_o == 8'h80);
endmodule

// File: tb/mem_row_selector_tb.sv
module mem_row_selector_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bank_win;
  logic [7:0] data;
  logic [1:0] strobe;
  logic       card_sel;
  logic       s_top, s_hi, s_small, s_mid, s_low;
  logic [7:0] row_sel;
  logic       mem_size;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_row_selector dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bank_win_i(bank_win), .data_i(data),
    .row_strobe_i(strobe), .card_sel_i(card_sel),
    .strap_top_bus_i(s_top), .strap_bit_hi_i(s_hi), .strap_size_small_i(s_small),
    .strap_mid_strobe_i(s_mid), .strap_low_strobe_i(s_low),
    .row_sel_o(row_sel), .mem_size_o(mem_size));

  task automatic cmp8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; bank_win = 1'b0; data = 8'h00; strobe = 2'b00; card_sel = 1'b1;
    s_top = 1'b1; s_hi = 1'b0; s_small = 1'b1; s_mid = 1'b1; s_low = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: captured bit cleared, all strobes low -> row 0
    #1 cmp8("R10", row_sel, 8'h01);
    cmp8("R6", {7'd0, mem_size}, 8'h01);

    for (int cfg = 0; cfg < 32; cfg++) begin
      for (int dv = 0; dv < 4; dv++) begin
        for (int sv = 0; sv < 4; sv++) begin
          for (int cs = 0; cs < 2; cs++) begin
            logic d4, d6, top, mid, low;
            logic [7:0] exp;
            @(negedge clk);
            {s_top, s_hi, s_small, s_mid, s_low} = cfg[4:0];
            d4 = dv[0]; d6 = dv[1];
            data = {1'b0, d6, 1'b0, d4, 4'h0};
            bank_win = 1'b1;
            card_sel = 1'b0;
            @(negedge clk);
            bank_win = 1'b0;
            data = ~data;
            @(negedge clk);
            strobe = sv[1:0];
            card_sel = cs[0];
            #1;
            top = s_top ? (s_hi ? d6 : d4) : 1'b1;
            mid = s_mid ? strobe[1] : 1'b1;
            low = s_low ? strobe[0] : 1'b1;
            exp = cs[0] ? (8'h01 << {top, mid, low}) : 8'h00;
            if (!cs[0])                     cmp8("R1", row_sel, exp);
            else if (!s_top && !s_mid && !s_low) cmp8("R9", row_sel, exp);
            else if (s_top)                 cmp8("R4 R5 R2 R7 R8", row_sel, exp);
            else                            cmp8("R3 R2 R7 R8", row_sel, exp);
            cmp8("R6", {7'd0, mem_size}, {7'd0, s_small});
          end
        end
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule